// File: doc/BRIEF.md
# Hardware Virtual-Opcode Dispatch Unit

This block removes the dispatch overhead from a software interpreter running on a small native processor. It holds a 16-bit virtual program counter alongside the native program counter. A dispatch command does the interpreter's fetch-and-branch in one clock cycle: the virtual counter is presented as the memory address, the 8-bit opcode that comes back becomes the high byte of the native program counter, the low byte is cleared, and the virtual counter advances.

Because the low byte is cleared, each virtual opcode owns one 256-word page of native code. Up to 256 opcodes can therefore be decoded, and each handler may use up to 256 native steps before it must jump elsewhere. Outside dispatch cycles the native counter behaves like an ordinary program counter, with a step input and a jump input. A load port lets handlers set the virtual counter directly, which is how virtual jumps and branches are emulated.

Top module: `vop_dispatch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both the virtual counter and the native counter read zero.
- R2: The memory address equals the virtual counter, zero-extended, in any cycle where dispatch is high. In every other cycle it equals the native counter.
- R3: After a dispatch cycle the native counter holds the opcode that memory returned in that cycle in bits 15:8 and zero in bits 7:0.
- R4: A dispatch cycle without a load advances the virtual counter by one, modulo 2^16, so that 0xFFFF becomes 0x0000.
- R5: A load cycle sets the virtual counter to the load value. When load and dispatch occur in the same cycle, the load value wins over the increment, and the native counter still takes the opcode fetched at the old virtual address.
- R6: The native counter takes its next value by priority: dispatch first, then jump (the counter takes the jump target), then step.
- R7: A step cycle with neither dispatch nor jump advances the native counter by one, modulo 2^16.
- R8: In a cycle with none of dispatch, load, jump or step, both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_i | input | 1 | Dispatch command |
| vpc_ld_i | input | 1 | Load the virtual counter |
| vpc_ld_val_i | input | 16 | Value for the virtual counter load |
| jmp_i | input | 1 | Native jump request |
| jmp_tgt_i | input | 16 | Native jump target |
| step_i | input | 1 | Native counter increment |
| mem_rdata_i | input | 8 | Opcode returned by memory in the same cycle |
| mem_addr_o | output | 16 | Memory address |
| npc_o | output | 16 | Native program counter |
| vpc_o | output | 16 | Virtual program counter |

## Verification
Two pairs of functions can share a cycle. The first is a dispatch together with a virtual-counter load. The second is a dispatch together with a native jump or step. The bench raises these strobes together on purpose. In the load case, it expects the virtual counter to hold the load value while the native page comes from the opcode fetched at the old address. In the native case, it expects the dispatch page to beat both the jump target and the increment. Its reference model computes the opcodes independently, from a memory function of the address.

// File: rtl/vop_dispatch.sv
module vop_dispatch #(
  parameter int VPC_W = 16,
  parameter int OP_W  = 8,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_i,
  input  logic             vpc_ld_i,
  input  logic [VPC_W-1:0] vpc_ld_val_i,
  input  logic             jmp_i,
  input  logic [OP_W+OFS_W-1:0] jmp_tgt_i,
  input  logic             step_i,
  input  logic [OP_W-1:0]  mem_rdata_i,
  output logic [((VPC_W > OP_W+OFS_W) ? VPC_W : OP_W+OFS_W)-1:0] mem_addr_o,
  output logic [OP_W+OFS_W-1:0] npc_o,
  output logic [VPC_W-1:0] vpc_o
);
  localparam int NPC_W = OP_W + OFS_W;
  localparam int ADR_W = (VPC_W > NPC_W) ? VPC_W : NPC_W;

  logic [VPC_W-1:0] vpc_q, vpc_d;
  logic [NPC_W-1:0] npc_q, npc_d;

  assign mem_addr_o = disp_i ? ADR_W'(vpc_q) : ADR_W'(npc_q);

  always_comb begin
    if (vpc_ld_i)    vpc_d = vpc_ld_val_i;
    else if (disp_i) vpc_d = vpc_q + 1'b1;
    else             vpc_d = vpc_q;
  end

  always_comb begin
    if (disp_i)      npc_d = {mem_rdata_i, {OFS_W{1'b0}}};
    else if (jmp_i)  npc_d = jmp_tgt_i;
    else if (step_i) npc_d = npc_q + 1'b1;
    else             npc_d = npc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpc_q <= '0;
      npc_q <= '0;
    end else begin
      vpc_q <= vpc_d;
      npc_q <= npc_d;
    end
  end

  assign vpc_o = vpc_q;
  assign npc_o = npc_q;

  // R1
  rst_zero_chk: assert property (@(posedge clk) !rst_n |=> (vpc_o == '0 && npc_o == '0));

  // R2
  addr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_i |-> mem_addr_o == ADR_W'(vpc_o));

  // R3
  disp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_i |=> npc_o == {$past(mem_rdata_i), {OFS_W{1'b0}}});

  // R4
  vpc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_i && !vpc_ld_i) |=> vpc_o == VPC_W'($past(vpc_o) + 1'b1));

  // R5
  vpc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpc_ld_i |=> vpc_o == $past(vpc_ld_val_i));

  // R6
  jmp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_i && jmp_i) |=> npc_o == $past(jmp_tgt_i));

  // R7
  npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_i && !jmp_i && step_i) |=> npc_o == NPC_W'($past(npc_o) + 1'b1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_i && !vpc_ld_i && !jmp_i && !step_i) |=> ($stable(vpc_o) && $stable(npc_o)));
endmodule

// File: tb/vop_dispatch_bench.sv
module vop_dispatch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_i = 1'b0, vpc_ld_i = 1'b0, jmp_i = 1'b0, step_i = 1'b0;
  logic [15:0] vpc_ld_val_i = '0, jmp_tgt_i = '0;
  logic [7:0]  mem_rdata_i;
  logic [15:0] mem_addr_o, npc_o, vpc_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] vpc;
    logic [15:0] npc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_vpc = '0, m_npc = '0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata_i = mem_fn(mem_addr_o);

  vop_dispatch u_vop_dispatch (
    .clk(clk), .rst_n(rst_n), .disp_i(disp_i), .vpc_ld_i(vpc_ld_i),
    .vpc_ld_val_i(vpc_ld_val_i), .jmp_i(jmp_i), .jmp_tgt_i(jmp_tgt_i),
    .step_i(step_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
    .npc_o(npc_o), .vpc_o(vpc_o)
  );

  task automatic check16(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic d, input logic ld, input logic [15:0] ldv,
                       input logic j, input logic [15:0] tgt, input logic s);
    exp_t e;
    logic [15:0] a;
    @(negedge clk);
    disp_i = d; vpc_ld_i = ld; vpc_ld_val_i = ldv; jmp_i = j; jmp_tgt_i = tgt; step_i = s;
    #1;
    a = d ? m_vpc : m_npc;
    check16("R2", "mem_addr", mem_addr_o, a);
    if (d)      m_npc = {mem_fn(m_vpc), 8'h00};
    else if (j) m_npc = tgt;
    else if (s) m_npc = m_npc + 16'd1;
    if (ld)     m_vpc = ldv;
    else if (d) m_vpc = m_vpc + 16'd1;
    e.vpc = m_vpc; e.npc = m_npc; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check16(e.tag, "vpc", vpc_o, e.vpc);
        check16(e.tag, "npc", npc_o, e.npc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check16("R1", "vpc in reset", vpc_o, 16'h0000);
    check16("R1", "npc in reset", npc_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    drive("R8", 0, 0, 16'h0000, 0, 16'h0000, 0);
    drive("R7", 0, 0, 16'h0000, 0, 16'h0000, 1);
    drive("R7", 0, 0, 16'h0000, 0, 16'h0000, 1);
    drive("R6", 0, 0, 16'h0000, 1, 16'h1234, 0);
    drive("R6", 0, 0, 16'h0000, 1, 16'h4321, 1);
    drive("R3", 1, 0, 16'h0000, 0, 16'h0000, 0);
    drive("R4", 1, 0, 16'h0000, 0, 16'h0000, 1);
    drive("R6", 1, 0, 16'h0000, 1, 16'hBEEF, 1);
    drive("R5", 0, 1, 16'hFFFE, 0, 16'h0000, 0);
    drive("R4", 1, 0, 16'h0000, 0, 16'h0000, 0);
    drive("R4", 1, 0, 16'h0000, 0, 16'h0000, 0);
    drive("R5", 1, 1, 16'h8000, 0, 16'h0000, 0);
    drive("R5", 1, 1, 16'h00A5, 1, 16'h7777, 0);
    drive("R7", 0, 0, 16'h0000, 1, 16'hFFFF, 0);
    drive("R7", 0, 0, 16'h0000, 0, 16'h0000, 1);
    drive("R8", 0, 0, 16'h0000, 0, 16'h0000, 0);
    for (int i = 0; i < 40; i++) begin
      drive("R3", 1, 0, 16'h0000, 0, 16'h0000, 0);
      drive("R7", 0, 0, 16'h0000, 0, 16'h0000, 1);
      if (i % 7 == 3) drive("R5", 0, 1, 16'(i * 16'h0123), 0, 16'h0000, 1);
    end
    drive("R8", 0, 0, 16'h0000, 0, 16'h0000, 0);
    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule